// File: doc/BRIEF.md
# Count/Compare Timer with Sticky Interrupt

This block is a free-running counter paired with a compare register. Each cycle in which the tick enable is high, the counter steps up by one. The tick enable is nominally pulsed at a 100 MHz rate and is generated outside the block. When a step brings the counter onto the compare value, the block raises a single interrupt line. That line stays high until software writes the compare register again.

Software may load either register at any time, and both are always visible on read-back ports. A compare write is also the acknowledge: it drops the interrupt, even when the value written equals the current count. A counter write leaves the interrupt level alone and leaves the compare value in place, so the next match is found against that value. A write never produces a match by itself. Only a counting step moves the counter into equality. Out of reset the compare register is 0 and the counter is 1, so the first match comes only when the counter wraps.

Top module: `cmp_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, the count reads 1, the compare reads 0 and the interrupt is low.
- R2: A cycle with tick enable high and no count write raises the count by exactly 1. A cycle with neither holds the count.
- R3: The count wraps from all ones to 0 with no event of its own; the interrupt rises there only when compare is 0.
- R4: When a tick step makes the count equal to compare, the interrupt is high from that same edge.
- R5: Once high, the interrupt stays high through further ticks and count writes until a compare write.
- R6: A compare write loads the compare value and drives the interrupt low at the next edge, even when the new value equals the count or a tick step would otherwise match in that cycle.
- R7: A count write loads the value, leaves compare and the interrupt level unchanged, and never raises the interrupt even if the loaded value equals compare; matching resumes against the kept compare on later ticks.
- R8: When count and compare writes fall in the same cycle, both registers load and the interrupt is low afterwards.
- R9: A count write takes priority over a tick in the same cycle: the count becomes the written value, not that value plus one.
- R10: The read ports show the register contents that were updated at the most recent edge, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-step enable, one step per high cycle |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | CNT_W | Count write value |
| cmp_wr | input | 1 | Compare register write strobe; also clears the interrupt |
| cmp_wdata | input | CNT_W | Compare write value |
| cnt_rdata | output | CNT_W | Current count |
| cmp_rdata | output | CNT_W | Current compare value |
| irq_o | output | 1 | Timer interrupt, level, held until a compare write |

## Verification
A corrupted count shows on cnt_rdata at the next edge. Its effect on the interrupt may appear much later, at the first step that should have matched, or it may appear early as a false match. A wrong interrupt state is visible on irq_o at once. It stays wrong because the level is sticky: a missed set lasts until the next match, and a stuck set lasts past the clearing compare write. The stimulus therefore checks irq_o on every cycle around matches, around writes that make the two values equal, and across the wrap point.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_CNT_W = 32;
  localparam int unsigned TMR_RST_COUNT = 1;
  localparam int unsigned TMR_RST_CMP = 0;
endpackage

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
  parameter int unsigned W = 32,
  parameter int unsigned RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_q,
  output logic         step_o,
  output logic [W-1:0] cnt_inc_o
);
  localparam logic [W-1:0] RST_CNT = W'(RST_VAL);
  localparam logic [W-1:0] ONE = W'(1);

  // a load wins over a step; the step is what arms matching
  assign step_o    = tick_en && !wr_en;
  assign cnt_inc_o = cnt_q + ONE;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= RST_CNT;
    else if (wr_en)  cnt_q <= wr_data;
    else if (tick_en) cnt_q <= cnt_inc_o;
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !wr_en) |=> (cnt_q == $past(cnt_q) + ONE));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr_en) |=> $stable(cnt_q));
  assert_load_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cnt_q == $past(wr_data)));
endmodule

// File: rtl/tmr_cmp_reg.sv
module tmr_cmp_reg #(
  parameter int unsigned W = 32,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cmp_q
);
  localparam logic [W-1:0] RST_CMP = W'(RST_VAL);

  always_ff @(posedge clk) begin
    if (rst)        cmp_q <= RST_CMP;
    else if (wr_en) cmp_q <= wr_data;
  end

  assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cmp_q));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  input  logic [W-1:0] cnt_inc_i,
  input  logic [W-1:0] cmp_i,
  input  logic         ack_i,
  output logic         irq_q
);
  logic hit;

  // only a counting step can move into equality; acknowledge dominates
  assign hit = step_i && !ack_i && (cnt_inc_i == cmp_i);

  always_ff @(posedge clk) begin
    if (rst)        irq_q <= 1'b0;
    else if (ack_i) irq_q <= 1'b0;
    else if (hit)   irq_q <= 1'b1;
  end

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !irq_q);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !ack_i) |=> irq_q);
  assert_no_step_no_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !irq_q) |=> !irq_q);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = TMR_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  output logic [CNT_W-1:0] cmp_rdata,
  output logic             irq_o
);
  logic             step;
  logic [CNT_W-1:0] cnt_inc;

  tmr_count_reg #(.W(CNT_W), .RST_VAL(TMR_RST_COUNT)) u_count (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(cnt_wr),
    .wr_data(cnt_wdata), .cnt_q(cnt_rdata), .step_o(step), .cnt_inc_o(cnt_inc)
  );

  tmr_cmp_reg #(.W(CNT_W), .RST_VAL(TMR_RST_CMP)) u_cmp (
    .clk(clk), .rst(rst), .wr_en(cmp_wr), .wr_data(cmp_wdata), .cmp_q(cmp_rdata)
  );

  tmr_irq_ctrl #(.W(CNT_W)) u_irq (
    .clk(clk), .rst(rst), .step_i(step), .cnt_inc_i(cnt_inc),
    .cmp_i(cmp_rdata), .ack_i(cmp_wr), .irq_q(irq_o)
  );

  assert_rise_on_match_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (cnt_rdata == cmp_rdata));
  assert_both_writes_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && cmp_wr) |=> (!irq_o && cnt_rdata == $past(cnt_wdata)
                             && cmp_rdata == $past(cmp_wdata)));
  assert_cnt_wr_no_fire_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !irq_o) |=> !irq_o);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (cnt_rdata == CNT_W'(TMR_RST_COUNT) && cmp_rdata == CNT_W'(TMR_RST_CMP) && !irq_o));
endmodule

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;
  localparam int W = 32;
  localparam int NV = 23;

  typedef struct packed {
    logic         tk;
    logic         cw;
    logic [W-1:0] cd;
    logic         mw;
    logic [W-1:0] md;
    logic [W-1:0] ec;
    logic [W-1:0] em;
    logic         ei;
  } vec_t;

  // each row: one cycle of stimulus and the state expected after its edge
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'd2, 32'd0, 1'b0},          // R2 step
    '{1'b0, 1'b0, 32'd0, 1'b0, 32'd0, 32'd2, 32'd0, 1'b0},          // R2 hold
    '{1'b0, 1'b0, 32'd0, 1'b1, 32'd5, 32'd2, 32'd5, 1'b0},          // R10 readback
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'd3, 32'd5, 1'b0},
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'd4, 32'd5, 1'b0},
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'd5, 32'd5, 1'b1},          // R4 match
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'd6, 32'd5, 1'b1},          // R5 sticky
    '{1'b0, 1'b1, 32'd100, 1'b0, 32'd0, 32'd100, 32'd5, 1'b1},      // R5/R7 count write keeps irq
    '{1'b0, 1'b0, 32'd0, 1'b1, 32'd100, 32'd100, 32'd100, 1'b0},    // R6 equal value clears
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'd101, 32'd100, 1'b0},
    '{1'b1, 1'b1, 32'd99, 1'b0, 32'd0, 32'd99, 32'd100, 1'b0},      // R9 write beats tick
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'd100, 32'd100, 1'b1},      // R7 re-armed
    '{1'b0, 1'b1, 32'd7, 1'b1, 32'd8, 32'd7, 32'd8, 1'b0},          // R8 both writes
    '{1'b0, 1'b1, 32'd8, 1'b0, 32'd0, 32'd8, 32'd8, 1'b0},          // R7 no fire on load
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'd9, 32'd8, 1'b0},
    '{1'b1, 1'b0, 32'd0, 1'b1, 32'd10, 32'd10, 32'd10, 1'b0},       // R6 ack beats match
    '{1'b0, 1'b1, 32'hFFFF_FFFE, 1'b1, 32'd0, 32'hFFFF_FFFE, 32'd0, 1'b0},
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'hFFFF_FFFF, 32'd0, 1'b0},
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'd0, 32'd0, 1'b1},          // R3 wrap match
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'd1, 32'd0, 1'b1},
    '{1'b0, 1'b0, 32'd0, 1'b1, 32'd3, 32'd1, 32'd3, 1'b0},          // R6 ack
    '{1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'd0, 32'hFFFF_FFFF, 32'd3, 1'b0},
    '{1'b1, 1'b0, 32'd0, 1'b0, 32'd0, 32'd0, 32'd3, 1'b0}           // R3 wrap no event
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b0;
  logic         cnt_wr = 1'b0;
  logic [W-1:0] cnt_wdata = '0;
  logic         cmp_wr = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic [W-1:0] cnt_rdata;
  logic [W-1:0] cmp_rdata;
  logic         irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cmp_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cnt_rdata(cnt_rdata),
    .cmp_rdata(cmp_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic tk, input logic cw, input logic [W-1:0] cd,
                       input logic mw, input logic [W-1:0] md);
    @(negedge clk);
    tick_en = tk; cnt_wr = cw; cnt_wdata = cd; cmp_wr = mw; cmp_wdata = md;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 count", cnt_rdata, 32'd1);
    check("R1 compare", cmp_rdata, 32'd0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 count after release", cnt_rdata, 32'd1);

    for (int i = 0; i < NV; i++) begin
      cycle(VECS[i].tk, VECS[i].cw, VECS[i].cd, VECS[i].mw, VECS[i].md);
      check($sformatf("R10 row %0d count", i), cnt_rdata, VECS[i].ec);
      check($sformatf("R10 row %0d compare", i), cmp_rdata, VECS[i].em);
      check($sformatf("R4 row %0d irq", i), {31'd0, irq_o}, {31'd0, VECS[i].ei});
    end

    // R5: long tick run with irq set must keep it high
    cycle(1'b0, 1'b1, 32'd19, 1'b1, 32'd20);
    cycle(1'b1, 1'b0, 32'd0, 1'b0, 32'd0);
    check("R4 irq at match 20", {31'd0, irq_o}, 32'd1);
    for (int k = 0; k < 10; k++) cycle(1'b1, 1'b0, 32'd0, 1'b0, 32'd0);
    check("R5 irq after ticks", {31'd0, irq_o}, 32'd1);
    check("R2 count after ticks", cnt_rdata, 32'd30);
    cycle(1'b0, 1'b0, 32'd0, 1'b1, 32'd30);
    check("R6 equal compare clears", {31'd0, irq_o}, 32'd0);

    // R1: reset in mid-run restores start state
    @(negedge clk);
    rst = 1'b1; tick_en = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid-run count", cnt_rdata, 32'd1);
    check("R1 mid-run compare", cmp_rdata, 32'd0);
    @(negedge clk);
    rst = 1'b0; tick_en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule